// File: doc/BRIEF.md
# SyncE Transient Test Stimulus Sequencer

This block scripts the stimulus for a boundary-clock conformance test. The test checks how the clock reacts when its frequency reference is re-arranged. The block drives a signed phase offset, in picoseconds, that a downstream synthesiser adds to an otherwise ideal SyncE reference. It also emits quality-level (QL) announcements at programmed moments, each as a code plus a one-cycle send strobe.

A start command arms the sequence and announces QL-PRC with zero phase offset. The block then waits for the device under test to report that it has settled. The transient then begins:
- an immediate 120 ns phase jump;
- a ramp of 50 ps per millisecond tick (50 ns/s);
- a QL-EEC announcement at a programmable delay inside a 1800–2000 ms window;
- at the 15 s mark, a re-lock event that discards the accumulated offset and applies a programmable re-lock step of at most 120 ns;
- a QL-PRC announcement at a programmable delay inside a 180–500 ms window after the mark.

After a final 85 s of ticks, test-done is raised. All timing counts an external millisecond tick exactly, which is well inside the ±1 % tolerance.

The delay and step settings are sampled when a start is accepted. A setting outside its legal range is clamped to the nearest legal value, and an error flag reports this for the run.

Top module: `synce_stim_seq`

## Requirements
- R1: After reset the phase offset is 0, the QL code is QL-PRC (4'h2), and the send strobe, transient marker, done flag and error flag are all low.
- R2: A start accepted while idle or done gives, on the next cycle, a one-cycle send strobe with QL-PRC and a phase offset of 0. No jump occurs, and the offset stays 0, until the stabilised input is seen high.
- R3: The cycle after the stabilised input is seen in the waiting state, the offset equals +120000 ps and the transient marker is high.
- R4: While the transient marker stays high, each millisecond tick adds exactly 50 ps to the offset, and the offset is unchanged on cycles without a tick. The offset never reaches 1000000 ps.
- R5: QL-EEC (4'hB) is sent exactly once, on the tick that brings the count since the jump to the programmed EEC delay. The QL code is always either 4'h2 or 4'hB.
- R6: On tick number MARK_MS (15000 by default) after the jump, the offset becomes the programmed re-lock step and the transient marker falls.
- R7: QL-PRC is sent exactly once after the mark, on the tick that brings the count since the mark to the programmed PRC delay.
- R8: The done flag rises on the HOLD_MS-th tick (85000 by default) after that QL-PRC send. It stays high, with the offset unchanged, until a new start is accepted.
- R9: The EEC delay is clamped to [1800,2000], the PRC delay to [180,500] and the re-lock step to at most 120000 ps. The error flag is high for a run in which any of them was clamped, and low for a run in which none was.
- R10: A start command while a sequence is running has no effect: no strobe, no change of offset or marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startCmd | input | 1 | Start request, accepted when idle or done |
| dutStable | input | 1 | Device under test reports it has settled |
| msTick | input | 1 | One-cycle pulse per elapsed millisecond |
| eecDelayMs | input | EEC_W | QL-EEC delay after the jump, in ms |
| prcDelayMs | input | PRC_W | QL-PRC delay after the mark, in ms |
| relockStepPs | input | RELOCK_W | Re-lock phase step in ps |
| phaseOffsetPs | output | PH_W | Signed phase offset in ps |
| qlCode | output | 4 | Current QL code |
| qlSend | output | 1 | One-cycle strobe: send qlCode |
| transientMark | output | 1 | High from the jump until re-lock |
| testDone | output | 1 | Sequence finished |
| cfgError | output | 1 | A setting was clamped in this run |

## Verification
The assertions assume that msTick is a clean pulse and that the re-lock step stays non-negative after clamping. They also assume that the EEC window ends before the mark, so no tick carries both an EEC send and the re-lock. The stimulus keeps to these assumptions. Ticks are single-cycle pulses separated by random idle gaps. The bench shortens the mark, hold time and windows through parameters while keeping the EEC window below the mark. Delays and steps are drawn both inside and outside their legal ranges, so that clamping is exercised without leaving the assumed envelope.

// File: rtl/synce_seq_pkg.sv
package synce_seq_pkg;

  localparam logic [3:0] QL_PRC_CODE = 4'h2;
  localparam logic [3:0] QL_EEC_CODE = 4'hB;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_STABLE,
    ST_TRANSIENT,
    ST_PRC_WAIT,
    ST_HOLD,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic clearPhase;
    logic loadJump;
    logic rampStep;
    logic loadRelock;
    logic sendPrc;
    logic sendEec;
  } seqStrobes_t;

endpackage

// File: rtl/synce_seq_ctrl.sv
module synce_seq_ctrl
  import synce_seq_pkg::*;
#(
  parameter int EEC_W      = 11,
  parameter int PRC_W      = 10,
  parameter int RELOCK_W   = 17,
  parameter int EEC_MIN    = 1800,
  parameter int EEC_MAX    = 2000,
  parameter int PRC_MIN    = 180,
  parameter int PRC_MAX    = 500,
  parameter int RELOCK_MAX = 120000,
  parameter int MARK_MS    = 15000,
  parameter int HOLD_MS    = 85000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startCmd,
  input  logic                dutStable,
  input  logic                msTick,
  input  logic [EEC_W-1:0]    eecDelayIn,
  input  logic [PRC_W-1:0]    prcDelayIn,
  input  logic [RELOCK_W-1:0] relockIn,
  output seqStrobes_t         strobes,
  output logic [RELOCK_W-1:0] relockStep,
  output logic                transientMark,
  output logic                testDone,
  output logic                cfgError
);

  localparam int CNT_MAX = (MARK_MS > HOLD_MS) ? MARK_MS : HOLD_MS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [EEC_W-1:0]    EEC_LO = EEC_W'(EEC_MIN);
  localparam logic [EEC_W-1:0]    EEC_HI = EEC_W'(EEC_MAX);
  localparam logic [PRC_W-1:0]    PRC_LO = PRC_W'(PRC_MIN);
  localparam logic [PRC_W-1:0]    PRC_HI = PRC_W'(PRC_MAX);
  localparam logic [RELOCK_W-1:0] REL_HI = RELOCK_W'(RELOCK_MAX);
  localparam logic [CNT_W-1:0]    MARK_CNT = CNT_W'(MARK_MS);
  localparam logic [CNT_W-1:0]    HOLD_CNT = CNT_W'(HOLD_MS);

  seqState_t            state;
  logic [CNT_W-1:0]     msCnt;
  logic [CNT_W-1:0]     nextCnt;
  logic [EEC_W-1:0]     eecReg;
  logic [PRC_W-1:0]     prcReg;
  logic [EEC_W-1:0]     eecClamped;
  logic [PRC_W-1:0]     prcClamped;
  logic [RELOCK_W-1:0]  relClamped;
  logic                 anyClamp;
  logic                 startOk;

  assign nextCnt = msCnt + 1'b1;
  assign startOk = startCmd && (state == ST_IDLE || state == ST_DONE);

  // Range limiting of the programmed settings
  always_comb begin
    eecClamped = eecDelayIn;
    prcClamped = prcDelayIn;
    relClamped = relockIn;
    anyClamp   = 1'b0;
    if (eecDelayIn < EEC_LO) begin eecClamped = EEC_LO; anyClamp = 1'b1; end
    if (eecDelayIn > EEC_HI) begin eecClamped = EEC_HI; anyClamp = 1'b1; end
    if (prcDelayIn < PRC_LO) begin prcClamped = PRC_LO; anyClamp = 1'b1; end
    if (prcDelayIn > PRC_HI) begin prcClamped = PRC_HI; anyClamp = 1'b1; end
    if (relockIn > REL_HI)   begin relClamped = REL_HI; anyClamp = 1'b1; end
  end

  // Strobes towards the datapath
  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE, ST_DONE: begin
        strobes.clearPhase = startCmd;
        strobes.sendPrc    = startCmd;
      end
      ST_WAIT_STABLE: strobes.loadJump = dutStable;
      ST_TRANSIENT: if (msTick) begin
        strobes.loadRelock = (nextCnt == MARK_CNT);
        strobes.rampStep   = (nextCnt != MARK_CNT);
        strobes.sendEec    = (nextCnt == CNT_W'(eecReg));
      end
      ST_PRC_WAIT: strobes.sendPrc = msTick && (nextCnt == CNT_W'(prcReg));
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      msCnt      <= '0;
      eecReg     <= EEC_LO;
      prcReg     <= PRC_LO;
      relockStep <= '0;
      cfgError   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (startOk) begin
          eecReg     <= eecClamped;
          prcReg     <= prcClamped;
          relockStep <= relClamped;
          cfgError   <= anyClamp;
          state      <= ST_WAIT_STABLE;
        end
        ST_WAIT_STABLE: if (dutStable) begin
          msCnt <= '0;
          state <= ST_TRANSIENT;
        end
        ST_TRANSIENT: if (msTick) begin
          if (nextCnt == MARK_CNT) begin
            msCnt <= '0;
            state <= ST_PRC_WAIT;
          end else begin
            msCnt <= nextCnt;
          end
        end
        ST_PRC_WAIT: if (msTick) begin
          if (nextCnt == CNT_W'(prcReg)) begin
            msCnt <= '0;
            state <= ST_HOLD;
          end else begin
            msCnt <= nextCnt;
          end
        end
        ST_HOLD: if (msTick) begin
          if (nextCnt == HOLD_CNT) begin
            msCnt <= '0;
            state <= ST_DONE;
          end else begin
            msCnt <= nextCnt;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign transientMark = (state == ST_TRANSIENT);
  assign testDone      = (state == ST_DONE);

endmodule

// File: rtl/synce_seq_datapath.sv
module synce_seq_datapath
  import synce_seq_pkg::*;
#(
  parameter int PH_W     = 32,
  parameter int RELOCK_W = 17,
  parameter int JUMP_PS  = 120000,
  parameter int RAMP_PS  = 50
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  seqStrobes_t            strobes,
  input  logic [RELOCK_W-1:0]    relockStep,
  output logic signed [PH_W-1:0] phaseOffsetPs,
  output logic [3:0]             qlCode,
  output logic                   qlSend
);

  localparam logic signed [PH_W-1:0] JUMP_VAL = PH_W'(JUMP_PS);
  localparam logic signed [PH_W-1:0] RAMP_VAL = PH_W'(RAMP_PS);

  logic signed [PH_W-1:0] relockVal;
  assign relockVal = $signed({{(PH_W-RELOCK_W){1'b0}}, relockStep});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseOffsetPs <= '0;
      qlCode        <= QL_PRC_CODE;
      qlSend        <= 1'b0;
    end else begin
      if (strobes.clearPhase)      phaseOffsetPs <= '0;
      else if (strobes.loadJump)   phaseOffsetPs <= JUMP_VAL;
      else if (strobes.loadRelock) phaseOffsetPs <= relockVal;
      else if (strobes.rampStep)   phaseOffsetPs <= phaseOffsetPs + RAMP_VAL;

      qlSend <= strobes.sendPrc || strobes.sendEec;
      if (strobes.sendEec)      qlCode <= QL_EEC_CODE;
      else if (strobes.sendPrc) qlCode <= QL_PRC_CODE;
    end
  end

endmodule

// File: rtl/synce_stim_seq.sv
module synce_stim_seq
  import synce_seq_pkg::*;
#(
  parameter int PH_W       = 32,
  parameter int EEC_W      = 11,
  parameter int PRC_W      = 10,
  parameter int RELOCK_W   = 17,
  parameter int JUMP_PS    = 120000,
  parameter int RAMP_PS    = 50,
  parameter int EEC_MIN    = 1800,
  parameter int EEC_MAX    = 2000,
  parameter int PRC_MIN    = 180,
  parameter int PRC_MAX    = 500,
  parameter int RELOCK_MAX = 120000,
  parameter int MARK_MS    = 15000,
  parameter int HOLD_MS    = 85000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   startCmd,
  input  logic                   dutStable,
  input  logic                   msTick,
  input  logic [EEC_W-1:0]       eecDelayMs,
  input  logic [PRC_W-1:0]       prcDelayMs,
  input  logic [RELOCK_W-1:0]    relockStepPs,
  output logic signed [PH_W-1:0] phaseOffsetPs,
  output logic [3:0]             qlCode,
  output logic                   qlSend,
  output logic                   transientMark,
  output logic                   testDone,
  output logic                   cfgError
);

  seqStrobes_t         strobes;
  logic [RELOCK_W-1:0] relockStep;

  synce_seq_ctrl #(
    .EEC_W(EEC_W), .PRC_W(PRC_W), .RELOCK_W(RELOCK_W),
    .EEC_MIN(EEC_MIN), .EEC_MAX(EEC_MAX),
    .PRC_MIN(PRC_MIN), .PRC_MAX(PRC_MAX),
    .RELOCK_MAX(RELOCK_MAX), .MARK_MS(MARK_MS), .HOLD_MS(HOLD_MS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startCmd(startCmd), .dutStable(dutStable),
    .msTick(msTick), .eecDelayIn(eecDelayMs), .prcDelayIn(prcDelayMs),
    .relockIn(relockStepPs), .strobes(strobes), .relockStep(relockStep),
    .transientMark(transientMark), .testDone(testDone), .cfgError(cfgError)
  );

  synce_seq_datapath #(
    .PH_W(PH_W), .RELOCK_W(RELOCK_W), .JUMP_PS(JUMP_PS), .RAMP_PS(RAMP_PS)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .relockStep(relockStep),
    .phaseOffsetPs(phaseOffsetPs), .qlCode(qlCode), .qlSend(qlSend)
  );

endmodule

// File: rtl/synce_stim_seq_chk.sv
module synce_stim_seq_chk #(
  parameter int PH_W       = 32,
  parameter int JUMP_PS    = 120000,
  parameter int RAMP_PS    = 50,
  parameter int RELOCK_MAX = 120000
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   startCmd,
  input logic                   msTick,
  input logic signed [PH_W-1:0] phaseOffsetPs,
  input logic [3:0]             qlCode,
  input logic                   qlSend,
  input logic                   transientMark,
  input logic                   testDone
);

  localparam logic signed [PH_W-1:0] JUMP_V  = PH_W'(JUMP_PS);
  localparam logic signed [PH_W-1:0] RAMP_V  = PH_W'(RAMP_PS);
  localparam logic signed [PH_W-1:0] RELOCK_V = PH_W'(RELOCK_MAX);
  localparam logic signed [PH_W-1:0] LIMIT_V = PH_W'(1000000);

  AST_SEND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    qlSend |=> !qlSend); // R2
  AST_JUMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(transientMark) |-> phaseOffsetPs == JUMP_V); // R3
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (transientMark && $past(transientMark) && $past(msTick)) |->
      phaseOffsetPs == $past(phaseOffsetPs) + RAMP_V); // R4
  AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (transientMark && $past(transientMark) && !$past(msTick)) |->
      $stable(phaseOffsetPs)); // R4
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phaseOffsetPs >= 0 && phaseOffsetPs < LIMIT_V); // R4
  AST_QL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    qlCode == 4'h2 || qlCode == 4'hB); // R5
  AST_RELOCK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(transientMark) |-> phaseOffsetPs <= RELOCK_V); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (testDone && !startCmd) |=> (testDone && $stable(phaseOffsetPs))); // R8

endmodule

bind synce_stim_seq synce_stim_seq_chk #(
  .PH_W(PH_W), .JUMP_PS(JUMP_PS), .RAMP_PS(RAMP_PS), .RELOCK_MAX(RELOCK_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .startCmd(startCmd), .msTick(msTick),
  .phaseOffsetPs(phaseOffsetPs), .qlCode(qlCode), .qlSend(qlSend),
  .transientMark(transientMark), .testDone(testDone)
);

// File: tb/synce_stim_seq_tb.sv
module synce_stim_seq_tb_top;

  localparam int PH_W = 32, EEC_W = 11, PRC_W = 10, RELOCK_W = 17;
  localparam int JUMP = 120000, RAMP = 50;
  localparam int EMIN = 100, EMAX = 160, PMIN = 20, PMAX = 50;
  localparam int RMAX = 120000, MARK = 400, HOLD = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startCmd = 1'b0, dutStable = 1'b0, msTick = 1'b0;
  logic [EEC_W-1:0] eecDelayMs = '0;
  logic [PRC_W-1:0] prcDelayMs = '0;
  logic [RELOCK_W-1:0] relockStepPs = '0;
  logic signed [PH_W-1:0] phaseOffsetPs;
  logic [3:0] qlCode;
  logic qlSend, transientMark, testDone, cfgError;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  synce_stim_seq #(
    .PH_W(PH_W), .EEC_W(EEC_W), .PRC_W(PRC_W), .RELOCK_W(RELOCK_W),
    .JUMP_PS(JUMP), .RAMP_PS(RAMP), .EEC_MIN(EMIN), .EEC_MAX(EMAX),
    .PRC_MIN(PMIN), .PRC_MAX(PMAX), .RELOCK_MAX(RMAX),
    .MARK_MS(MARK), .HOLD_MS(HOLD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .startCmd(startCmd), .dutStable(dutStable),
    .msTick(msTick), .eecDelayMs(eecDelayMs), .prcDelayMs(prcDelayMs),
    .relockStepPs(relockStepPs), .phaseOffsetPs(phaseOffsetPs),
    .qlCode(qlCode), .qlSend(qlSend), .transientMark(transientMark),
    .testDone(testDone), .cfgError(cfgError)
  );

  function automatic int clampI(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doTick();
    msTick = 1'b1;
    @(negedge clk);
    msTick = 1'b0;
  endtask

  task automatic gap();
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic runSeq(int eIn, int pIn, int rIn);
    int eEff, pEff, rEff;
    bit expErr;
    longint expPh;
    eEff = clampI(eIn, EMIN, EMAX);
    pEff = clampI(pIn, PMIN, PMAX);
    rEff = (rIn > RMAX) ? RMAX : rIn;
    expErr = (eEff != eIn) || (pEff != pIn) || (rEff != rIn);
    eecDelayMs = EEC_W'(eIn);
    prcDelayMs = PRC_W'(pIn);
    relockStepPs = RELOCK_W'(rIn);
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    chk(qlSend && qlCode == 4'h2, "R2 start PRC send", {qlSend, qlCode}, 5'h12);
    chk(phaseOffsetPs == 0 && !testDone, "R2 start phase", phaseOffsetPs, 0);
    chk(cfgError == expErr, "R9 clamp flag", cfgError, expErr);
    eecDelayMs = '0; prcDelayMs = '0; relockStepPs = '1;
    repeat (3) begin doTick(); gap(); end
    chk(phaseOffsetPs == 0 && !transientMark && !qlSend, "R2 waits for stable",
        phaseOffsetPs, 0);
    dutStable = 1'b1;
    @(negedge clk);
    dutStable = 1'b0;
    chk(phaseOffsetPs == JUMP && transientMark, "R3 jump", phaseOffsetPs, JUMP);
    for (int i = 1; i <= MARK; i++) begin
      doTick();
      if (i < MARK) begin
        expPh = JUMP + RAMP * i;
        chk(phaseOffsetPs == expPh, "R4 ramp", phaseOffsetPs, expPh);
        chk(qlSend == (i == eEff), "R5 EEC timing", qlSend, (i == eEff));
        if (i == eEff)
          chk(qlCode == 4'hB, "R5 EEC code", qlCode, 4'hB);
      end else begin
        chk(phaseOffsetPs == rEff && !transientMark, "R6 relock", phaseOffsetPs, rEff);
      end
      if (i == MARK / 2) begin
        startCmd = 1'b1;
        @(negedge clk);
        startCmd = 1'b0;
        chk(!qlSend && transientMark && phaseOffsetPs == expPh,
            "R10 start ignored", phaseOffsetPs, expPh);
      end
      gap();
    end
    for (int j = 1; j <= pEff; j++) begin
      doTick();
      chk(qlSend == (j == pEff), "R7 PRC timing", qlSend, (j == pEff));
      if (j == pEff) chk(qlCode == 4'h2, "R7 PRC code", qlCode, 4'h2);
      chk(phaseOffsetPs == rEff, "R6 relock held", phaseOffsetPs, rEff);
      gap();
    end
    for (int k = 1; k <= HOLD; k++) begin
      doTick();
      chk(testDone == (k == HOLD), "R8 done timing", testDone, (k == HOLD));
      gap();
    end
    repeat (4) begin doTick(); gap(); end
    chk(testDone && phaseOffsetPs == rEff && !qlSend, "R8 done holds",
        phaseOffsetPs, rEff);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phaseOffsetPs == 0 && qlCode == 4'h2, "R1 reset phase/code", phaseOffsetPs, 0);
    chk(!qlSend && !transientMark && !testDone && !cfgError, "R1 reset flags",
        {qlSend, transientMark, testDone, cfgError}, 0);
    runSeq(130, 35, 60000);
    runSeq(EMIN, PMIN, 0);
    runSeq(EMAX, PMAX, RMAX);
    runSeq(5, 600, 131071);
    runSeq(2000, 0, 1000);
    for (int n = 0; n < 3; n++)
      runSeq($urandom_range(60, 200), $urandom_range(0, 80), $urandom_range(0, 131071));
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule